// File: doc/BRIEF.md
# Two-Input Reversible Counter with Cascade Strobes

This block is a 4-bit binary counter that counts in both directions. Each direction has its own count input. A low-to-high change on the up input adds one, and a low-to-high change on the down input subtracts one. The count wraps between 15 and 0 in both directions. A free-running system clock samples both count inputs through synchronizers and detects their rising edges. Clear and parallel preset act on the visible count in the same cycle they are asserted.

Two active-low strobes, carry and borrow, let counters be chained. Carry is low while the count is at its maximum and the up input is low. Borrow is low while the count is zero and the down input is low. Wiring carry to the next stage's up input and borrow to its down input gives a wider counter with no glue logic. When the low stage wraps, its strobe rises together with its count input, so both stages step on the same system cycle.

All pins are plain level signals. Nothing flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `updn_chain_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released with both count inputs high, `count_q` is 0 and `carry_n` and `borrow_n` are 1. Reset leaves both edge detectors idle, so a count input that is already high gives no step.
- R2: A low-to-high change on `cnt_up_in` while `cnt_dn_in` is held high adds one to the count, wrapping 15 to 0. The new value appears after the third rising `clk` edge that samples the input high.
- R3: A low-to-high change on `cnt_dn_in` while `cnt_up_in` is held high subtracts one from the count, wrapping 0 to 15, with the same latency as R2.
- R4: A low-to-high change on one count input while the other count input is low leaves the count unchanged.
- R5: If both count inputs are detected rising on the same system cycle, the count keeps its value.
- R6: While `preset_n` is 0 and `clear` is 0, `count_q` equals `data_in` in the same cycle. The value stays after `preset_n` returns to 1. Count edges detected during the preset are discarded.
- R7: While `clear` is 1, `count_q` is 0 in the same cycle, whatever `preset_n`, `data_in` and the count inputs do. Count edges detected during the clear are discarded.
- R8: `carry_n` is 0 exactly when `count_q` is 15 and `cnt_up_in` is 0. `borrow_n` is 0 exactly when `count_q` is 0 and `cnt_dn_in` is 0. Both strobes follow the inputs combinationally.
- R9: Two instances wired as a cascade (low stage `carry_n` to high stage `cnt_up_in`, low stage `borrow_n` to high stage `cnt_dn_in`) count as one 8-bit counter in both directions, wrapping modulo 256.
- R10: After a clear and a preset to 13, five up pulses give 14, 15, 0, 1, 2. Five down pulses after that give 1, 0, 15, 14, 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_up_in | input | 1 | Count-up input; a rising edge increments |
| cnt_dn_in | input | 1 | Count-down input; a rising edge decrements |
| clear | input | 1 | Active-high clear, highest priority |
| preset_n | input | 1 | Active-low parallel preset |
| data_in | input | 4 | Preset value |
| count_q | output | 4 | Current count |
| carry_n | output | 1 | Active-low carry strobe for the next stage's up input |
| borrow_n | output | 1 | Active-low borrow strobe for the next stage's down input |

## Verification
The bench goes after both wrap points. A design with a wrong modulus or a wrong direction fails the 15-to-0 and 0-to-15 steps of the fixed sequence. It raises one count input while the other is low, and raises both together. A design that ignores the gating level, or lets one edge win, moves the count in those cases. It presets and clears while edges are arriving and then releases. A design that queues those edges moves the count afterwards, and one that registers preset or clear shows the old count for a cycle. A two-stage cascade is counted across several wraps in both directions. Strobes that are registered, or that ignore the count input level, make the high stage step late, step twice or miss a step.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10
  } step_t;
endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH:0] stage_r;

  // stage 0 takes the raw input; stage DEPTH is the one-cycle-old copy of the last stage
  genvar g;
  generate
    for (g = 0; g <= DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_r[g] <= 1'b1;
          else        stage_r[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_r[g] <= 1'b1;
          else        stage_r[g] <= stage_r[g-1];
        end
      end
    end
  endgenerate

  assign level = stage_r[LAST];
  assign rise  = stage_r[LAST] & ~stage_r[DEPTH];

  // a detected edge lasts exactly one cycle
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/updn_step_arb.sv
module updn_step_arb
  import updn_pkg::*;
(
  input  logic  up_rise,
  input  logic  up_lvl,
  input  logic  dn_rise,
  input  logic  dn_lvl,
  output step_t step
);
  always_comb begin
    step = STEP_HOLD;
    if (up_rise && dn_rise)     step = STEP_HOLD;
    else if (up_rise && dn_lvl) step = STEP_INC;
    else if (dn_rise && up_lvl) step = STEP_DEC;
  end
endmodule

// File: rtl/updn_state.sv
module updn_state
  import updn_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             preset_n,
  input  logic [CNT_W-1:0] data_in,
  input  step_t            step,
  output logic [CNT_W-1:0] count_r,
  output logic [CNT_W-1:0] count_vis
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    next_cnt = count_r;
    unique case (step)
      STEP_INC: next_cnt = count_r + ONE;
      STEP_DEC: next_cnt = count_r - ONE;
      default:  next_cnt = count_r;
    endcase
    if (clear)          next_cnt = '0;
    else if (!preset_n) next_cnt = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_r <= '0;
    else        count_r <= next_cnt;
  end

  // clear and preset reach the output without waiting for a clock edge
  always_comb begin
    if (clear)          count_vis = '0;
    else if (!preset_n) count_vis = data_in;
    else                count_vis = count_r;
  end

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_r == '0));
  assert_preset_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !preset_n) |=> (count_r == $past(data_in)));
endmodule

// File: rtl/updn_cascade_flags.sv
module updn_cascade_flags #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count_vis,
  input  logic             up_in,
  input  logic             dn_in,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign carry_n  = ~((count_vis == TOP) & ~up_in);
  assign borrow_n = ~((count_vis == '0) & ~dn_in);
endmodule

// File: rtl/updn_chain_counter.sv
module updn_chain_counter
  import updn_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up_in,
  input  logic             cnt_dn_in,
  input  logic             clear,
  input  logic             preset_n,
  input  logic [CNT_W-1:0] data_in,
  output logic [CNT_W-1:0] count_q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             up_lvl, up_rise, dn_lvl, dn_rise;
  step_t            step;
  logic [CNT_W-1:0] count_r;

  updn_edge_sync #(.DEPTH(SYNC_DEPTH)) u_up_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_up_in), .level(up_lvl), .rise(up_rise));

  updn_edge_sync #(.DEPTH(SYNC_DEPTH)) u_dn_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_dn_in), .level(dn_lvl), .rise(dn_rise));

  updn_step_arb u_arb (
    .up_rise(up_rise), .up_lvl(up_lvl), .dn_rise(dn_rise), .dn_lvl(dn_lvl), .step(step));

  updn_state #(.CNT_W(CNT_W)) u_state (
    .clk(clk), .rst_n(rst_n), .clear(clear), .preset_n(preset_n), .data_in(data_in),
    .step(step), .count_r(count_r), .count_vis(count_q));

  updn_cascade_flags #(.CNT_W(CNT_W)) u_flags (
    .count_vis(count_q), .up_in(cnt_up_in), .dn_in(cnt_dn_in),
    .carry_n(carry_n), .borrow_n(borrow_n));

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rise && dn_lvl && !dn_rise && !clear && preset_n)
      |=> (count_r == $past(count_r) + ONE));
  assert_dn_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rise && up_lvl && !up_rise && !clear && preset_n)
      |=> (count_r == $past(count_r) - ONE));
  assert_gated_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rise && !dn_lvl && !dn_rise && !clear && preset_n) |=> $stable(count_r));
  assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rise && dn_rise && !clear && preset_n) |=> $stable(count_r));
  assert_carry_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (count_q == TOP));
  assert_borrow_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (count_q == '0));
endmodule

// File: tb/updn_chain_counter_tb_top.sv
`timescale 1ns/100ps
module updn_chain_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b1, dn = 1'b1, clr = 1'b0, pre_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q, q_hi;
  logic cy_n, bw_n, cy_hi_n, bw_hi_n;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updn_chain_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_up_in(up), .cnt_dn_in(dn), .clear(clr),
    .preset_n(pre_n), .data_in(din), .count_q(q), .carry_n(cy_n), .borrow_n(bw_n));

  updn_chain_counter dut_hi (
    .clk(clk), .rst_n(rst_n), .cnt_up_in(cy_n), .cnt_dn_in(bw_n), .clear(clr),
    .preset_n(1'b1), .data_in(4'd0), .count_q(q_hi), .carry_n(cy_hi_n), .borrow_n(bw_hi_n));

  // behavioural reference: raw input history per edge, step from history ages 1 and 2
  int m_cnt = 0;
  bit uh[3] = '{1, 1, 1};
  bit dh[3] = '{1, 1, 1};
  always @(posedge clk) begin
    bit ru, rd;
    ru = uh[1] && !uh[2];
    rd = dh[1] && !dh[2];
    if (!rst_n) begin
      m_cnt = 0; uh = '{1, 1, 1}; dh = '{1, 1, 1};
    end else begin
      if (clr) m_cnt = 0;
      else if (!pre_n) m_cnt = din;
      else if (ru && rd) m_cnt = m_cnt;
      else if (ru && dh[1]) m_cnt = (m_cnt + 1) % 16;
      else if (rd && uh[1]) m_cnt = (m_cnt + 15) % 16;
      uh[2] = uh[1]; uh[1] = uh[0]; uh[0] = up;
      dh[2] = dh[1]; dh[1] = dh[0]; dh[0] = dn;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // every cycle: compare the three outputs with the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int eq;
      eq = clr ? 0 : (!pre_n ? int'(din) : m_cnt);
      chk("R2 R3 R6 R7 model count", q, eq);
      chk("R8 model carry", cy_n, !(eq == 15 && !up));
      chk("R8 model borrow", bw_n, !(eq == 0 && !dn));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic pulse_up();
    up = 1'b0; cyc(3); up = 1'b1; cyc(6);
  endtask
  task automatic pulse_dn();
    dn = 1'b0; cyc(3); dn = 1'b1; cyc(6);
  endtask
  task automatic at_neg();
    @(negedge clk); #0.1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_seq_up[5] = '{14, 15, 0, 1, 2};
    int exp_seq_dn[5] = '{1, 0, 15, 14, 13};
    cyc(3);
    chk("R1 count in reset", q, 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 count after reset", q, 0);
    chk("R1 carry idle", cy_n, 1);
    chk("R1 borrow idle", bw_n, 1);

    // clear overrides a simultaneous preset
    clr = 1'b1; pre_n = 1'b0; din = 4'd5;
    at_neg(); chk("R7 clear same cycle over preset", q, 0);
    cyc(1); clr = 1'b0; din = 4'd13;
    at_neg(); chk("R6 preset same cycle", q, 13);
    cyc(2); pre_n = 1'b1; cyc(2);
    chk("R6 preset retained", q, 13);
    foreach (exp_seq_up[i]) begin
      pulse_up(); chk("R10 R2 up sequence", q, exp_seq_up[i]);
    end
    foreach (exp_seq_dn[i]) begin
      pulse_dn(); chk("R10 R3 down sequence", q, exp_seq_dn[i]);
    end

    // strobes
    pre_n = 1'b0; din = 4'd15; cyc(2); pre_n = 1'b1; cyc(2);
    up = 1'b0; at_neg(); chk("R8 carry low at 15 with up low", cy_n, 0);
    chk("R8 borrow high at 15", bw_n, 1);
    dn = 1'b0; at_neg(); chk("R8 borrow high when not zero", bw_n, 1);
    dn = 1'b1; up = 1'b1; at_neg(); chk("R8 carry high with up high", cy_n, 1);
    cyc(6);
    pre_n = 1'b0; din = 4'd0; cyc(2); pre_n = 1'b1; cyc(2);
    dn = 1'b0; at_neg(); chk("R8 borrow low at 0 with down low", bw_n, 0);

    // up edge while down low is ignored
    cyc(1); pulse_up();
    chk("R4 up edge with down low", q, 0);
    dn = 1'b1; cyc(6);
    chk("R3 down edge wraps 0 to 15", q, 15);
    pulse_up(); chk("R2 up edge wraps 15 to 0", q, 0);

    // both edges together
    up = 1'b0; dn = 1'b0; cyc(4); up = 1'b1; dn = 1'b1; cyc(6);
    chk("R5 simultaneous edges hold", q, 0);

    // edges during preset and clear are dropped
    pre_n = 1'b0; din = 4'd9; cyc(1); pulse_up(); pulse_dn(); pre_n = 1'b1; cyc(6);
    chk("R6 edges during preset discarded", q, 9);
    clr = 1'b1; cyc(1); pulse_up(); clr = 1'b0; cyc(6);
    chk("R7 edges during clear discarded", q, 0);

    // two-stage cascade
    clr = 1'b1; cyc(2); clr = 1'b0; cyc(2);
    for (int k = 0; k < 20; k++) pulse_up();
    chk("R9 cascade up to 20", {q_hi, q}, 20);
    for (int k = 0; k < 22; k++) pulse_dn();
    chk("R9 cascade down to 254", {q_hi, q}, 254);
    for (int k = 0; k < 3; k++) pulse_up();
    chk("R9 cascade wrap to 1", {q_hi, q}, 1);

    cyc(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule